// File: doc/BRIEF.md
# Counter-Compare Watchdog Timer

This block is a watchdog that sits on a free-running 16-bit counter. The counter advances on a tick enable chosen from several sources: the system clock divided by twelve, divided by four, an external tick input, or the system clock itself. The watchdog never counts down a private timer. Instead, a kick stores a match byte: the counter's current high byte plus a programmed offset. A timeout happens only when the low byte rolls over from 0xFF while the high byte equals that match byte. The interval after a kick, counted in ticks and including the tick of the kick edge, is therefore 256 × offset + (256 − low byte at the kick).

Software reaches the block through a small write port with four addresses: control, offset, kick and flag. The watchdog is active when either the enable bit or the sticky lock bit is set. Clock-source and idle-suspend changes are accepted only while it is inactive. Writing the flag with bit 0 set while active forces an immediate watchdog reset. When the block fires, it emits a one-cycle reset pulse and returns all of its own state to the power-up defaults.

Top module: `cmp_watchdog`

## Requirements
- R1: After `rst` the block holds enable=1, lock=0, source=0 (system clock ÷12), idle-suspend=0, offset=0, match=0, flag=0 and count=0. With no further writes, the first watchdog pulse appears after exactly 3072 clock edges from the first edge with `rst` low.
- R2: The 3-bit source field (control bits 4:2) selects the tick as follows. Code 0 ticks every 12 clocks. Code 1 ticks every 4 clocks. Code 2 ticks on each cycle with `ext_tick` high. Code 3 ticks on every clock. Codes 4 to 7 behave as code 0.
- R3: The counter adds one on each tick. When idle-suspend (control bit 5) is set and `cpu_idle` is high, the counter holds.
- R4: A write to address 2 (kick) while active loads match with (count high byte + offset) mod 256. While inactive, a kick leaves match unchanged.
- R5: While active, a timeout fires at an edge where a tick occurs, the low byte is 0xFF and the high byte equals match. Counting from the edge after a kick, the timeout comes 256 × offset + 255 − L edges later, where L is the low byte at the kick, for a source of code 3.
- R6: A write to address 3 with bit 0 set while active fires at once. While inactive, a write to address 3 stores bit 0 into the flag and fires nothing.
- R7: Active = enable (control bit 0) OR lock (control bit 1). Lock can be set but never cleared by a write. Clearing enable while lock is 0 stops all timeouts.
- R8: While active, writes to control leave the source field and idle-suspend unchanged.
- R9: A firing raises `wdt_rst` for one cycle. In that same cycle all status outputs show the R1 defaults, including lock=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| cpu_idle | input | 1 | CPU idle indication, suspends counting when idle-suspend is set |
| ext_tick | input | 1 | External tick enable, one cycle per tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 offset, 2 kick, 3 flag |
| wr_data | input | 8 | Write data |
| wdt_rst | output | 1 | One-cycle watchdog reset pulse |
| stat_en | output | 1 | Enable bit |
| stat_lock | output | 1 | Lock bit |
| stat_active | output | 1 | Watchdog currently active |
| stat_src | output | 3 | Selected tick source |
| stat_idle_sus | output | 1 | Idle-suspend setting |
| stat_flag | output | 1 | Flag bit |
| stat_offset | output | 8 | Programmed offset |
| stat_match | output | 8 | Match byte |
| stat_count | output | 16 | Counter value |

## Verification
The hardest case to reach is a timeout at a chosen interval with a nonzero low-byte phase. The default ÷12 tick would make each interval last thousands of cycles, and the source cannot be changed while the watchdog is active. The stimulus first clears enable, switches to the per-clock source, programs the offset and re-enables. It then issues the kick at a moment when the low byte is not zero, and predicts the firing edge from the low byte seen just before the kick edge. Lock is exercised by setting it with enable cleared. A forced firing is the only way back out of that state, and the checks confirm that this firing clears lock.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

    localparam int CNT_W        = 16;
    localparam int MATCH_W      = 8;
    localparam int LOW_W        = CNT_W - MATCH_W;
    localparam int DEF_SLOW_DIV = 12;
    localparam int DEF_FAST_DIV = 4;

    // control word bit positions
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_LOCK_BIT = 1;
    localparam int CTRL_SRC_LSB  = 2;
    localparam int CTRL_SRC_W    = 3;
    localparam int CTRL_IDLE_BIT = 5;
    localparam int FLAG_BIT      = 0;

    typedef enum logic [1:0] {
        A_CTRL   = 2'd0,
        A_OFFSET = 2'd1,
        A_KICK   = 2'd2,
        A_FLAG   = 2'd3
    } reg_addr_e;

    typedef enum logic [CTRL_SRC_W-1:0] {
        SRC_SLOW = 3'd0,
        SRC_FAST = 3'd1,
        SRC_EXT  = 3'd2,
        SRC_SYS  = 3'd3
    } tick_src_e;

    typedef struct packed {
        logic                  idle_sus;
        logic [CTRL_SRC_W-1:0] src;
        logic                  lock;
        logic                  en;
    } cfg_t;

    localparam cfg_t CFG_DEFAULT = '{idle_sus: 1'b0, src: SRC_SLOW, lock: 1'b0, en: 1'b1};

    // choose the tick enable for a source code; reserved codes fall back to the slow tick
    function automatic logic pick_tick(input logic [CTRL_SRC_W-1:0] src,
                                       input logic slow, input logic fast, input logic ext);
        logic t;
        case (src)
            SRC_FAST: t = fast;
            SRC_EXT:  t = ext;
            SRC_SYS:  t = 1'b1;
            default:  t = slow;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/cwd_tick_gen.sv
module cwd_tick_gen
    import cwd_pkg::*;
#(
    parameter int SLOW_DIV = DEF_SLOW_DIV,
    parameter int FAST_DIV = DEF_FAST_DIV
) (
    input  logic                  clk,
    input  logic                  clr,
    input  logic [CTRL_SRC_W-1:0] src,
    input  logic                  ext_tick,
    output logic                  tick
);
    localparam int SW = $clog2(SLOW_DIV);

    logic [SW-1:0] slow_q;
    logic          slow_tick;
    logic          fast_tick;

    assign slow_tick = (slow_q == SW'(SLOW_DIV - 1));

    always_ff @(posedge clk) begin
        if (clr)            slow_q <= '0;
        else if (slow_tick) slow_q <= '0;
        else                slow_q <= slow_q + SW'(1);
    end

    generate
        if (SLOW_DIV % FAST_DIV == 0) begin : g_shared
            // fast tick taken from the slow divider phase
            assign fast_tick = ((int'(slow_q) % FAST_DIV) == (FAST_DIV - 1));
        end else begin : g_own
            localparam int FW = $clog2(FAST_DIV);
            logic [FW-1:0] fast_q;
            assign fast_tick = (fast_q == FW'(FAST_DIV - 1));
            always_ff @(posedge clk) begin
                if (clr)            fast_q <= '0;
                else if (fast_tick) fast_q <= '0;
                else                fast_q <= fast_q + FW'(1);
            end
        end
    endgenerate

    assign tick = pick_tick(src, slow_tick, fast_tick, ext_tick);

endmodule

// File: rtl/cwd_counter.sv
module cwd_counter #(
    parameter int LO_W = 8,
    parameter int HI_W = 8
) (
    input  logic                 clk,
    input  logic                 clr,
    input  logic                 adv,
    output logic [LO_W+HI_W-1:0] cnt_q,
    output logic                 low_wrap
);
    localparam int W = LO_W + HI_W;

    assign low_wrap = adv & (&cnt_q[LO_W-1:0]);

    always_ff @(posedge clk) begin
        if (clr)      cnt_q <= '0;
        else if (adv) cnt_q <= cnt_q + W'(1);
    end

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (clr)
        !adv |=> $stable(cnt_q)); // R3

endmodule

// File: rtl/cwd_regs.sv
module cwd_regs
    import cwd_pkg::*;
(
    input  logic               clk,
    input  logic               clr,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [7:0]         wr_data,
    input  logic [MATCH_W-1:0] cnt_hi,
    output cfg_t               cfg_q,
    output logic [MATCH_W-1:0] offset_q,
    output logic [MATCH_W-1:0] match_q,
    output logic               flag_q,
    output logic               active,
    output logic               force_req
);
    logic wr_ctrl, wr_off, wr_kick, wr_flag;

    assign active    = cfg_q.en | cfg_q.lock;
    assign wr_ctrl   = wr_en && (wr_addr == A_CTRL);
    assign wr_off    = wr_en && (wr_addr == A_OFFSET);
    assign wr_kick   = wr_en && (wr_addr == A_KICK);
    assign wr_flag   = wr_en && (wr_addr == A_FLAG);
    assign force_req = wr_flag && wr_data[FLAG_BIT] && active;

    always_ff @(posedge clk) begin
        if (clr) begin
            cfg_q    <= CFG_DEFAULT;
            offset_q <= '0;
            match_q  <= '0;
            flag_q   <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                cfg_q.en   <= wr_data[CTRL_EN_BIT];
                cfg_q.lock <= cfg_q.lock | wr_data[CTRL_LOCK_BIT];
                if (!active) begin
                    cfg_q.src      <= wr_data[CTRL_SRC_LSB +: CTRL_SRC_W];
                    cfg_q.idle_sus <= wr_data[CTRL_IDLE_BIT];
                end
            end
            if (wr_off)            offset_q <= wr_data[MATCH_W-1:0];
            if (wr_kick && active) match_q  <= cnt_hi + offset_q;
            if (wr_flag)           flag_q   <= wr_data[FLAG_BIT];
        end
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (clr)
        cfg_q.lock |=> cfg_q.lock); // R7

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (clr)
        active |=> ($stable(cfg_q.src) && $stable(cfg_q.idle_sus))); // R8

    AST_KICK_IGNORED: assert property (@(posedge clk) disable iff (clr)
        (!active && wr_kick) |=> $stable(match_q)); // R4

endmodule

// File: rtl/cmp_watchdog.sv
module cmp_watchdog
    import cwd_pkg::*;
#(
    parameter int SLOW_DIV = DEF_SLOW_DIV,
    parameter int FAST_DIV = DEF_FAST_DIV
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cpu_idle,
    input  logic                  ext_tick,
    input  logic                  wr_en,
    input  logic [1:0]            wr_addr,
    input  logic [7:0]            wr_data,
    output logic                  wdt_rst,
    output logic                  stat_en,
    output logic                  stat_lock,
    output logic                  stat_active,
    output logic [CTRL_SRC_W-1:0] stat_src,
    output logic                  stat_idle_sus,
    output logic                  stat_flag,
    output logic [MATCH_W-1:0]    stat_offset,
    output logic [MATCH_W-1:0]    stat_match,
    output logic [CNT_W-1:0]      stat_count
);
    logic               tick, adv, low_wrap, hit, fire, clr, pulse_q;
    logic               active, force_req, flag;
    logic [CNT_W-1:0]   cnt;
    logic [MATCH_W-1:0] offset, match;
    cfg_t               cfg;

    // a firing acts as a synchronous clear of the whole block
    assign clr = rst | fire;

    cwd_tick_gen #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_tick (
        .clk      (clk),
        .clr      (clr),
        .src      (cfg.src),
        .ext_tick (ext_tick),
        .tick     (tick)
    );

    assign adv = tick & ~(cfg.idle_sus & cpu_idle);

    cwd_counter #(.LO_W(LOW_W), .HI_W(MATCH_W)) u_cnt (
        .clk      (clk),
        .clr      (clr),
        .adv      (adv),
        .cnt_q    (cnt),
        .low_wrap (low_wrap)
    );

    cwd_regs u_regs (
        .clk       (clk),
        .clr       (clr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cnt_hi    (cnt[CNT_W-1 -: MATCH_W]),
        .cfg_q     (cfg),
        .offset_q  (offset),
        .match_q   (match),
        .flag_q    (flag),
        .active    (active),
        .force_req (force_req)
    );

    assign hit  = active & low_wrap & (cnt[CNT_W-1 -: MATCH_W] == match);
    assign fire = hit | force_req;

    always_ff @(posedge clk) begin
        if (rst) pulse_q <= 1'b0;
        else     pulse_q <= fire;
    end

    assign wdt_rst       = pulse_q;
    assign stat_en       = cfg.en;
    assign stat_lock     = cfg.lock;
    assign stat_active   = active;
    assign stat_src      = cfg.src;
    assign stat_idle_sus = cfg.idle_sus;
    assign stat_flag     = flag;
    assign stat_offset   = offset;
    assign stat_match    = match;
    assign stat_count    = cnt;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (wdt_rst && !force_req) |=> !wdt_rst); // R9

    AST_DEFAULTS_ON_FIRE: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |-> (stat_en && !stat_lock && stat_count == '0 &&
                     stat_offset == '0 && stat_match == '0)); // R9

    AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (stat_idle_sus && cpu_idle && !fire) |=> $stable(stat_count)); // R3

    AST_INACTIVE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!stat_active && !(wr_en && wr_addr == A_CTRL)) |=> !wdt_rst); // R7

endmodule

// File: tb/cmp_watchdog_bench.sv
module cmp_watchdog_bench;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst = 1'b1, cpu_idle = 1'b0, ext_tick = 1'b0, wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [7:0]  wr_data = 8'd0;
    logic        wdt_rst, stat_en, stat_lock, stat_active, stat_idle_sus, stat_flag;
    logic [2:0]  stat_src;
    logic [7:0]  stat_offset, stat_match;
    logic [15:0] stat_count;

    cmp_watchdog u_cmp_watchdog (
        .clk(clk), .rst(rst), .cpu_idle(cpu_idle), .ext_tick(ext_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wdt_rst(wdt_rst), .stat_en(stat_en), .stat_lock(stat_lock),
        .stat_active(stat_active), .stat_src(stat_src), .stat_idle_sus(stat_idle_sus),
        .stat_flag(stat_flag), .stat_offset(stat_offset), .stat_match(stat_match),
        .stat_count(stat_count)
    );

    int checks = 0, fails = 0, cyc = 0;
    bit cmp_on = 0;

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_p12 = 0, m_p4 = 0;
    int m_cnt = 0, m_match = 0, m_off = 0, m_src = 0;
    bit m_en = 1, m_lock = 0, m_idle = 0, m_flag = 0, m_pulse = 0;
    bit m_act, m_tick, m_adv, m_fire;

    task automatic model_defaults();
        m_p12 = 0; m_p4 = 0; m_cnt = 0; m_match = 0; m_off = 0; m_src = 0;
        m_en = 1; m_lock = 0; m_idle = 0; m_flag = 0;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            model_defaults();
            m_pulse = 0;
        end else begin
            m_act = m_en || m_lock;
            case (m_src)
                1: m_tick = (m_p4 == 3);
                2: m_tick = ext_tick;
                3: m_tick = 1;
                default: m_tick = (m_p12 == 11);
            endcase
            m_adv  = m_tick && !(m_idle && cpu_idle);
            m_fire = m_act && m_adv && (m_cnt % 256 == 255) && (m_cnt / 256 == m_match);
            if (m_act && wr_en && wr_addr == 2'd3 && wr_data[0]) m_fire = 1;
            if (m_fire) begin
                model_defaults();
                m_pulse = 1;
            end else begin
                m_pulse = 0;
                m_p12 = (m_p12 + 1) % 12;
                m_p4  = (m_p4 + 1) % 4;
                if (wr_en) begin
                    case (wr_addr)
                        2'd0: begin
                            if (!m_act) begin
                                m_src  = int'(wr_data[4:2]);
                                m_idle = wr_data[5];
                            end
                            m_en = wr_data[0];
                            if (wr_data[1]) m_lock = 1;
                        end
                        2'd1: m_off = int'(wr_data);
                        2'd2: if (m_act) m_match = (m_cnt / 256 + m_off) % 256;
                        default: m_flag = wr_data[0];
                    endcase
                end
                if (m_adv) m_cnt = (m_cnt + 1) % 65536;
            end
        end
    end

    // compared on every clock, away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            check("R9 pulse", int'(wdt_rst), int'(m_pulse));
            check("R3 count", int'(stat_count), m_cnt);
            check("R4 match", int'(stat_match), m_match);
            check("R7 active", int'(stat_active), int'(m_en || m_lock));
            check("R7 lock", int'(stat_lock), int'(m_lock));
            check("R8 source", int'(stat_src), m_src);
            check("R8 idle", int'(stat_idle_sus), int'(m_idle));
            check("R6 flag", int'(stat_flag), int'(m_flag));
            check("R1 offset", int'(stat_offset), m_off);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic wait_pulse(output int n);
        n = 0;
        while (!wdt_rst) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n, pulses, lo, hi;
        logic [15:0] c0;
        logic [7:0]  m0;

        repeat (3) @(negedge clk);
        rst = 0;
        cmp_on = 1;
        // R1 reset state
        check("R1 en", int'(stat_en), 1);
        check("R1 lock", int'(stat_lock), 0);
        check("R1 src", int'(stat_src), 0);
        check("R1 count", int'(stat_count), 0);
        check("R1 match", int'(stat_match), 0);
        // R1 default timeout
        wait_pulse(n);
        check("R1 default interval", n, 3072);
        check("R9 defaults count", int'(stat_count), 0);
        check("R9 defaults en", int'(stat_en), 1);
        @(negedge clk);
        check("R9 single cycle", int'(wdt_rst), 0);

        // R7 clearing enable stops timeouts
        wr(2'd0, 8'h00);
        check("R7 inactive", int'(stat_active), 0);
        pulses = 0;
        repeat (3300) begin
            @(negedge clk);
            if (wdt_rst) pulses++;
        end
        check("R7 no timeout", pulses, 0);

        // R2 source selection
        wr(2'd0, 8'h0C);
        check("R8 src accepted inactive", int'(stat_src), 3);
        c0 = stat_count; repeat (10) @(negedge clk);
        check("R2 sysclk", int'(16'(stat_count - c0)), 10);
        wr(2'd0, 8'h04);
        c0 = stat_count; repeat (40) @(negedge clk);
        check("R2 div4", int'(16'(stat_count - c0)), 10);
        wr(2'd0, 8'h08);
        c0 = stat_count;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); ext_tick = 1;
            @(negedge clk); ext_tick = 0;
            @(negedge clk);
        end
        check("R2 external", int'(16'(stat_count - c0)), 5);
        wr(2'd0, 8'h14);
        c0 = stat_count; repeat (120) @(negedge clk);
        check("R2 reserved code", int'(16'(stat_count - c0)), 10);

        // R3 idle suspend
        wr(2'd0, 8'h2C);
        cpu_idle = 1;
        c0 = stat_count; repeat (20) @(negedge clk);
        check("R3 idle hold", int'(16'(stat_count - c0)), 0);
        cpu_idle = 0;
        c0 = stat_count; repeat (20) @(negedge clk);
        check("R3 resume", int'(16'(stat_count - c0)), 20);
        wr(2'd0, 8'h0C);

        // R4 kick ignored while inactive
        wr(2'd1, 8'h05);
        m0 = stat_match;
        wr(2'd2, 8'h00);
        check("R4 kick inactive", int'(stat_match), int'(m0));

        // R6 flag while inactive
        wr(2'd3, 8'h01);
        check("R6 flag set", int'(stat_flag), 1);
        check("R6 no pulse inactive", int'(wdt_rst), 0);
        @(negedge clk);
        check("R6 no pulse later", int'(wdt_rst), 0);
        wr(2'd3, 8'h00);
        check("R6 flag clear", int'(stat_flag), 0);

        // R5 measured interval with offset 2 on the per-clock source
        wr(2'd1, 8'h02);
        wr(2'd0, 8'h0D);
        repeat (37) @(negedge clk);
        lo = int'(stat_count[7:0]);
        hi = int'(stat_count[15:8]);
        wr_en = 1; wr_addr = 2'd2; wr_data = 8'h00;
        @(negedge clk);
        wr_en = 0;
        check("R4 kick match", int'(stat_match), (hi + 2) % 256);
        wait_pulse(n);
        check("R5 interval", n, 256 * 2 + 255 - lo);

        // R7 lock and R8 freeze
        wr(2'd0, 8'h02);
        check("R7 lock set", int'(stat_lock), 1);
        wr(2'd0, 8'h0C);
        check("R7 lock holds active", int'(stat_active), 1);
        check("R7 lock sticky", int'(stat_lock), 1);
        check("R8 src frozen", int'(stat_src), 0);

        // R6 forced firing, R9 clears lock
        wr(2'd3, 8'h01);
        check("R6 forced pulse", int'(wdt_rst), 1);
        check("R9 lock cleared", int'(stat_lock), 0);
        @(negedge clk);
        check("R9 pulse drops", int'(wdt_rst), 0);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule